// File: doc/BRIEF.md
# Ethernet Multicast Hash Filter

This block decides whether a received frame should be kept by looking only at its 48-bit destination MAC address. The six address bytes arrive one per valid cycle, with a start strobe on the first. The block runs a reflected CRC-32 over them one byte per cycle. It folds the CRC into a 6-bit index and looks that index up in a 64-bit hash table. The decision appears as an accept/reject flag with a one-cycle valid strobe. Receiving the rest of the frame, checking the frame check sequence and matching the unicast station address are handled elsewhere.

The table is programmed as four 16-bit words through a simple write port. A separate write port loads two mode bits. The promiscuous mode accepts everything. The all-multicast mode accepts every group-addressed frame whatever the table holds. A frame is a group frame when bit 0 of its first address byte is 1. The all-ones broadcast address is always accepted.

The controller is a two-state machine. ST_IDLE waits for a first byte, which is byte_valid together with byte_start. Taking that byte is the transition START, which goes to ST_COLLECT. ST_COLLECT takes further bytes until the sixth. Taking the sixth byte is the transition FINISH, which returns to ST_IDLE and issues the decision. In ST_COLLECT, a new first byte is the transition RESTART, which stays in ST_COLLECT and throws away the partial address. Cycles without byte_valid leave the state unchanged. A synchronous reset forces ST_IDLE.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash is a CRC-32 with the reflected polynomial 0xEDB88320 and a seed of all ones, with no final inversion. It is computed over exactly the six address bytes, first byte first, and each byte is taken least significant bit first.
- R2: CRC bits [5:0] are reversed to form the index, so index bit 5 is CRC bit 0 and index bit 0 is CRC bit 5. A group frame is accepted when bit (index) of the flat 64-bit table is 1. Index bits [5:3] pick the table byte and index bits [2:0] pick the bit inside that byte. Flat bit i is bit (i mod 16) of word i/16, so word k holds table byte 2k in bits [7:0] and table byte 2k+1 in bits [15:8].
- R3: A cycle with tbl_wr high loads tbl_data into the word selected by tbl_sel. The other three words keep their contents.
- R4: When promiscuous mode is off, a frame with bit 0 of its first byte equal to 0 is rejected, whatever the table holds and whether or not all-multicast mode is on.
- R5: The destination FF:FF:FF:FF:FF:FF is accepted even when the table is all zeros and both modes are off.
- R6: With all-multicast mode on, every group frame is accepted even when the table is all zeros.
- R7: With promiscuous mode on, every frame is accepted, unicast frames included. Promiscuous mode also turns all-multicast mode on.
- R8: dec_valid is high for exactly one cycle, in the cycle that follows the clock edge that takes the sixth byte. Cycles with byte_valid low do not count as bytes. dec_accept is low whenever dec_valid is low.
- R9: A first byte (byte_valid and byte_start) that arrives while an address is being collected discards the partial address and starts a new one. Bytes that arrive without byte_start while in ST_IDLE are ignored.
- R10: A synchronous reset clears the table, both mode bits and the address progress, and holds dec_valid and dec_accept low.
- R11: A cycle with mode_wr high loads both mode bits. The decision uses the mode bits that are held when the sixth byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | byte_data carries an address byte this cycle |
| byte_start | input | 1 | Marks the first address byte (used only when byte_valid is high) |
| byte_data | input | 8 | Address byte |
| tbl_wr | input | 1 | Write strobe for the hash table |
| tbl_sel | input | 2 | Table word to write |
| tbl_data | input | 16 | Table word value |
| mode_wr | input | 1 | Write strobe for the mode bits |
| mode_promisc | input | 1 | Promiscuous mode value to load |
| mode_allmulti | input | 1 | All-multicast mode value to load |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Accept when high, reject when low |

## Verification
The bench walks a single set bit through all 64 table positions. For each position it searches for a group address whose hash lands on exactly that bit, using its own bit-serial CRC. A design that reflects the index the wrong way, reads the CRC from the wrong end or swaps the halves of a table word would reject that address or accept a neighbour. It also sends addresses with idle gaps between bytes, and addresses abandoned after three bytes and restarted. A controller that counted idle cycles, or that kept a stale partial CRC, would raise the strobe early or hash the wrong bytes. Further frames cover unicast frames under the all-multicast mode, broadcast with an empty table, and a reset taken after the table was filled. These show a design that lets the modes leak into unicast decisions or whose reset misses the table or the mode bits.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CRC_W  = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_COLLECT
    } mhf_state_e;

    // Eight reflected CRC steps, data bit 0 first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  crc_in,
        input logic [BYTE_W-1:0] din
    );
        logic [CRC_W-1:0] r;
        logic             fb;
        r = crc_in;
        for (int j = 0; j < BYTE_W; j++) begin
            fb = r[0] ^ din[j];
            r  = r >> 1;
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit
    import mhf_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [BYTE_W-1:0] byte_data,
    output logic [IDX_W-1:0]  idx
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nx;

    assign crc_nx = crc_step_byte(load ? CRC_SEED : crc_q, byte_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_SEED;
        end else if (load || adv) begin
            crc_q <= crc_nx;
        end
    end

    // Index is the low CRC bits in reversed order, taken from the value
    // the register is about to hold so the last byte needs no extra cycle.
    for (genvar b = 0; b < IDX_W; b++) begin : g_rev
        assign idx[b] = crc_nx[IDX_W-1-b];
    end

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned WORDS  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [$clog2(WORDS)-1:0]  sel,
    input  logic [WORD_W-1:0]         data,
    output logic [WORDS*WORD_W-1:0]   flat
);

    localparam int unsigned SEL_W = $clog2(WORDS);

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr && (sel == SEL_W'(k))) begin
                word_q <= data;
            end
        end

        assign flat[k*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/mhf_frame_fsm.sv
module mhf_frame_fsm
    import mhf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic              byte_start,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              crc_load,
    output logic              crc_adv,
    output logic              addr_done,
    output logic              grp_q,
    output logic              bcast_hit
);

    localparam int unsigned CNT_W = $clog2(ADDR_BYTES);
    localparam int unsigned LAST  = ADDR_BYTES - 1;

    mhf_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             grp_d;
    logic             ones_q, ones_d;
    logic             is_ff;
    logic             take_first;

    assign is_ff      = (byte_data == {BYTE_W{1'b1}});
    assign take_first = byte_valid && byte_start;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            grp_q   <= 1'b0;
            ones_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            grp_q   <= grp_d;
            ones_q  <= ones_d;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        grp_d     = grp_q;
        ones_d    = ones_q;
        crc_load  = 1'b0;
        crc_adv   = 1'b0;
        addr_done = 1'b0;
        if (take_first) begin
            // START from ST_IDLE, RESTART from ST_COLLECT
            state_d  = ST_COLLECT;
            cnt_d    = CNT_W'(1);
            grp_d    = byte_data[0];
            ones_d   = is_ff;
            crc_load = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_COLLECT: begin
                    if (byte_valid) begin
                        crc_adv = 1'b1;
                        ones_d  = ones_q && is_ff;
                        if (cnt_q == CNT_W'(LAST)) begin
                            // FINISH
                            addr_done = 1'b1;
                            state_d   = ST_IDLE;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign bcast_hit = addr_done && ones_q && is_ff;

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned TBL_WORDS  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          byte_valid,
    input  logic                          byte_start,
    input  logic [7:0]                    byte_data,
    input  logic                          tbl_wr,
    input  logic [$clog2(TBL_WORDS)-1:0]  tbl_sel,
    input  logic [WORD_W-1:0]             tbl_data,
    input  logic                          mode_wr,
    input  logic                          mode_promisc,
    input  logic                          mode_allmulti,
    output logic                          dec_valid,
    output logic                          dec_accept
);

    localparam int unsigned TBL_BITS = TBL_WORDS * WORD_W;
    localparam int unsigned IDX_W    = $clog2(TBL_BITS);

    logic                promisc_q;
    logic                allmulti_q;
    logic                w_load;
    logic                w_adv;
    logic                w_done;
    logic                w_grp;
    logic                w_bcast;
    logic [IDX_W-1:0]    w_idx;
    logic [TBL_BITS-1:0] w_tbl;
    logic                accept_calc;

    mhf_frame_fsm #(.ADDR_BYTES(ADDR_BYTES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_start (byte_start),
        .byte_data  (byte_data),
        .crc_load   (w_load),
        .crc_adv    (w_adv),
        .addr_done  (w_done),
        .grp_q      (w_grp),
        .bcast_hit  (w_bcast)
    );

    mhf_crc_unit #(.IDX_W(IDX_W)) u_crc (
        .clk       (clk),
        .rst       (rst),
        .load      (w_load),
        .adv       (w_adv),
        .byte_data (byte_data),
        .idx       (w_idx)
    );

    mhf_hash_table #(.WORD_W(WORD_W), .WORDS(TBL_WORDS)) u_tbl (
        .clk  (clk),
        .rst  (rst),
        .wr   (tbl_wr),
        .sel  (tbl_sel),
        .data (tbl_data),
        .flat (w_tbl)
    );

    // Mode bits; promiscuous implies all-multicast
    always_ff @(posedge clk) begin
        if (rst) begin
            promisc_q  <= 1'b0;
            allmulti_q <= 1'b0;
        end else if (mode_wr) begin
            promisc_q  <= mode_promisc;
            allmulti_q <= mode_allmulti || mode_promisc;
        end
    end

    assign accept_calc = promisc_q ||
                         (w_grp && (allmulti_q || w_bcast || w_tbl[w_idx]));

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= w_done;
            dec_accept <= w_done && accept_calc;
        end
    end

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter int unsigned TBL_BITS = 64
) (
    input logic                clk,
    input logic                rst,
    input logic                byte_valid,
    input logic                dec_valid,
    input logic                dec_accept,
    input logic                promisc_q,
    input logic                allmulti_q,
    input logic                grp_q,
    input logic [TBL_BITS-1:0] tbl_flat
);

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid); // R8

    AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        dec_accept |-> dec_valid); // R8

    AST_VALID_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(byte_valid)); // R8

    AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && $past(promisc_q)) |-> dec_accept); // R7

    AST_ALLMULTI_GROUP: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && $past(allmulti_q) && grp_q) |-> dec_accept); // R6

    AST_UNICAST_REJECT: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !$past(promisc_q) && !grp_q) |-> !dec_accept); // R4

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dec_valid && (tbl_flat == '0) && !promisc_q && !allmulti_q)); // R10

endmodule

bind mcast_hash_filter mhf_checker u_mhf_checker (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .promisc_q  (promisc_q),
    .allmulti_q (allmulti_q),
    .grp_q      (w_grp),
    .tbl_flat   (w_tbl)
);

// File: tb/test_mcast_hash_filter.sv
module test_mcast_hash_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic        byte_valid, byte_start;
    logic [7:0]  byte_data;
    logic        tbl_wr;
    logic [1:0]  tbl_sel;
    logic [15:0] tbl_data;
    logic        mode_wr, mode_promisc, mode_allmulti;
    logic        dec_valid, dec_accept;

    int n_chk  = 0;
    int n_fail = 0;

    logic [63:0] tbl_m;
    logic        pr_m, am_m;
    logic [63:0] rs = 64'h9E3779B97F4A7C15;

    always #5 clk = ~clk;

    mcast_hash_filter i_mcast_hash_filter (
        .clk(clk), .rst(rst),
        .byte_valid(byte_valid), .byte_start(byte_start), .byte_data(byte_data),
        .tbl_wr(tbl_wr), .tbl_sel(tbl_sel), .tbl_data(tbl_data),
        .mode_wr(mode_wr), .mode_promisc(mode_promisc), .mode_allmulti(mode_allmulti),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Bit-serial model over the 48 address bits in wire order
    function automatic logic [5:0] exp_index(input logic [47:0] a);
        logic [31:0] c;
        logic        fb;
        logic [5:0]  ix;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            fb = c[0] ^ a[i];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        for (int b = 0; b < 6; b++) ix[5-b] = c[b];
        return ix;
    endfunction

    function automatic logic exp_accept(input logic [47:0] a);
        logic grp, bc;
        grp = a[0];
        bc  = (a == 48'hFFFF_FFFF_FFFF);
        return pr_m | (grp & (am_m | pr_m | bc | tbl_m[exp_index(a)]));
    endfunction

    task automatic get_rand(output logic [47:0] a);
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 7);
        rs = rs ^ (rs << 17);
        a = rs[47:0];
    endtask

    task automatic wr_word(input int k, input logic [15:0] d);
        tbl_wr = 1'b1; tbl_sel = 2'(k); tbl_data = d;
        @(negedge clk);
        tbl_wr = 1'b0;
        tbl_m[16*k +: 16] = d;
    endtask

    task automatic wr_table(input logic [63:0] t);
        for (int k = 0; k < 4; k++) wr_word(k, t[16*k +: 16]);
    endtask

    task automatic wr_mode(input logic p, input logic m);
        mode_wr = 1'b1; mode_promisc = p; mode_allmulti = m;
        @(negedge clk);
        mode_wr = 1'b0;
        pr_m = p; am_m = m | p;
    endtask

    task automatic send_bytes(input logic [47:0] a, input int n, input bit with_start);
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1;
            byte_start = with_start && (i == 0);
            byte_data  = a[8*i +: 8];
            @(negedge clk);
            byte_valid = 1'b0;
            byte_start = 1'b0;
        end
    endtask

    task automatic run_frame(input logic [47:0] a, input int gap, input string req);
        int   early;
        logic v, acc, after, e;
        early = 0;
        for (int i = 0; i < 6; i++) begin
            byte_valid = 1'b1;
            byte_start = (i == 0);
            byte_data  = a[8*i +: 8];
            @(negedge clk);
            byte_valid = 1'b0;
            byte_start = 1'b0;
            if (i < 5) begin
                early += int'(dec_valid);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    early += int'(dec_valid);
                end
            end
        end
        v   = dec_valid;
        acc = dec_accept;
        @(negedge clk);
        after = dec_valid;
        e = exp_accept(a);
        chk(v === 1'b1, "R8", "valid after sixth byte", int'(v), 1);
        chk(early == 0 && after === 1'b0, "R8", "stray valid cycles",
            early + int'(after), 0);
        chk(acc === e, req, "accept", int'(acc), int'(e));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        tbl_m = '0; pr_m = 1'b0; am_m = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [47:0] a;
        rst = 1'b1;
        byte_valid = 0; byte_start = 0; byte_data = 0;
        tbl_wr = 0; tbl_sel = 0; tbl_data = 0;
        mode_wr = 0; mode_promisc = 0; mode_allmulti = 0;
        tbl_m = '0; pr_m = 0; am_m = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(dec_valid === 1'b0 && dec_accept === 1'b0, "R10", "outputs after reset",
            int'({dec_valid, dec_accept}), 0);

        // R5 broadcast with empty table, R4 unicast rejected
        run_frame(48'hFFFF_FFFF_FFFF, 0, "R5");
        run_frame(48'h0000_1234_5600, 0, "R4");

        // R1 R2: walk a single table bit, hit it exactly
        for (int p = 0; p < 64; p++) begin
            wr_table(64'd1 << p);
            do begin
                get_rand(a);
                a[0] = 1'b1;
            end while (exp_index(a) != 6'(p));
            run_frame(a, 0, "R1 R2");
            get_rand(a);
            a[0] = 1'b1;
            run_frame(a, 0, "R2");
        end

        // R3: word-by-word writes leave the other words alone
        wr_table('0);
        for (int k = 0; k < 4; k++) begin
            get_rand(a);
            wr_word(k, a[15:0]);
            for (int f = 0; f < 16; f++) begin
                get_rand(a);
                a[0] = 1'b1;
                run_frame(a, 0, "R3");
            end
        end

        // R6 all-multicast, R4 unicast still rejected
        wr_table('0);
        wr_mode(1'b0, 1'b1);
        for (int f = 0; f < 8; f++) begin
            get_rand(a);
            a[0] = 1'b1;
            run_frame(a, 0, "R6");
            a[0] = 1'b0;
            run_frame(a, 0, "R4");
        end

        // R7 promiscuous, R11 mode write back to filtering
        wr_mode(1'b1, 1'b0);
        for (int f = 0; f < 6; f++) begin
            get_rand(a);
            run_frame(a, 0, "R7");
        end
        wr_mode(1'b0, 1'b0);
        get_rand(a);
        a[0] = 1'b1;
        run_frame(a, 0, "R11");
        a[0] = 1'b0;
        run_frame(a, 0, "R11");

        // R8 idle gaps between bytes
        get_rand(a);
        wr_table(a[47:0] ^ {a[15:0], 48'h0});
        for (int g = 1; g < 4; g++) begin
            for (int f = 0; f < 4; f++) begin
                get_rand(a);
                a[0] = 1'b1;
                run_frame(a, g, "R8");
            end
        end

        // R9 restart mid-address and stray bytes in idle
        for (int f = 0; f < 6; f++) begin
            get_rand(a);
            send_bytes(a, 3, 1'b1);
            chk(dec_valid === 1'b0, "R9", "no valid on partial", int'(dec_valid), 0);
            get_rand(a);
            a[0] = 1'b1;
            run_frame(a, 0, "R9");
            get_rand(a);
            send_bytes(a, 6, 1'b0);
            chk(dec_valid === 1'b0, "R9", "stray bytes ignored", int'(dec_valid), 0);
            get_rand(a);
            a[0] = 1'b1;
            run_frame(a, 0, "R9");
        end

        // R10 reset clears table and modes
        wr_table('1);
        wr_mode(1'b1, 1'b1);
        do_reset();
        chk(dec_valid === 1'b0, "R10", "valid low after reset", int'(dec_valid), 0);
        get_rand(a);
        a[0] = 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) a[1] = 1'b0;
        run_frame(a, 0, "R10");
        a[0] = 1'b0;
        run_frame(a, 0, "R10");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule